// File: doc/BRIEF.md
# Dual Compare Timer with Security-Qualified Mask Override

This block holds two 64-bit compare timers, one physical and one virtual, both fed from an external free-running system count. Each timer has its own enable and mask bits and a compare value. The virtual timer compares the count minus an offset register against its compare value. The physical timer compares the raw count. Each timer raises a status flag when the count reaches the compare value and drives an interrupt line from that flag.

A separate hypervisor control register holds two override bits, one for each timer. While the core reports one of the two most privileged security states, a set override bit forces that timer's interrupt low, whatever its own mask bit says. The interrupt lines are therefore recomputed on every cycle. They follow a change to the override bits or to the security-state input, and do not wait for a change in a timer.

Software reaches the registers through a single-cycle write port. The security state is a 2-bit input.

Top module: `cmp_timer_pair`

## Requirements
- R1: After reset the compare values, the virtual offset and both timer control registers are zero, so both status flags and both interrupts are low. The hypervisor control register resets to 3, which leaves its bits 18 and 19 clear.
- R2: The write port uses these addresses: 0 is the physical control register, 1 the physical compare value, 2 the virtual control register, 3 the virtual compare value, 4 the virtual offset and 5 the hypervisor control register. In a control register, bit 0 enables the timer and bit 1 masks its interrupt.
- R3: While the physical timer is enabled, its status flag is 1 exactly when the count is greater than or equal to its compare value, compared as unsigned 64-bit numbers.
- R4: While the virtual timer is enabled, its status flag is 1 exactly when (count − offset) modulo 2^64 is greater than or equal to its compare value.
- R5: A disabled timer has its status flag at 0 and its interrupt low.
- R6: A timer's interrupt is high only when its status flag is 1 and its mask bit is 0.
- R7: When the security state is 2 (Root) or 3 (Realm), hypervisor control bit 18 forces the virtual interrupt low and bit 19 forces the physical interrupt low.
- R8: When the security state is 0 (Secure) or 1 (Non-secure), bits 18 and 19 have no effect on either interrupt.
- R9: A change of security state updates both interrupts on the same clock edge.
- R10: One write that changes both bit 18 and bit 19 updates both interrupts together.
- R11: Outputs are registered. A change of the count or security-state input shows on the outputs after the next clock edge. A register write shows after the edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_count | input | 64 | Free-running system count |
| sec_state | input | 2 | Security state (0 Secure, 1 Non-secure, 2 Root, 3 Realm) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| irq_phys | output | 1 | Physical timer interrupt |
| irq_virt | output | 1 | Virtual timer interrupt |
| stat_phys | output | 1 | Physical timer status flag |
| stat_virt | output | 1 | Virtual timer status flag |

## Verification
A security-state change and a write to the hypervisor override bits can land on the same clock edge. The bench provokes this by moving the state from Secure to Root on the same edge as a write that clears both override bits, with both timers firing. On the first edge the state is already Root but the old override bits are still in force, so both interrupts must fall. On the next edge the new override bits apply, so both must rise again. This ordering is exactly what R9, R10 and R11 predict.

// File: rtl/ct_pkg.sv
// Package: shared constants and types for the dual compare timer.
// Assumes a 3-bit register address space and 64-bit counting.
package ct_pkg;
    localparam int TMR_PHYS = 0;
    localparam int TMR_VIRT = 1;
    localparam int NUM_TMR  = 2;

    localparam logic [2:0] A_PHYS_CTL = 3'd0;
    localparam logic [2:0] A_PHYS_CMP = 3'd1;
    localparam logic [2:0] A_VIRT_CTL = 3'd2;
    localparam logic [2:0] A_VIRT_CMP = 3'd3;
    localparam logic [2:0] A_VIRT_OFF = 3'd4;
    localparam logic [2:0] A_HYP_CTL  = 3'd5;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_MASK_BIT  = 1;
    localparam int HYP_VMASK_BIT = 18;
    localparam int HYP_PMASK_BIT = 19;
    localparam logic [31:0] HYP_RESET = 32'd3;

    typedef enum logic [1:0] {
        SEC_SECURE = 2'd0,
        SEC_NONSEC = 2'd1,
        SEC_ROOT   = 2'd2,
        SEC_REALM  = 2'd3
    } sec_e;

    // True when the hypervisor override bits are honoured.
    function automatic logic override_active(input logic [1:0] s);
        return (s == SEC_ROOT) || (s == SEC_REALM);
    endfunction
endpackage

// File: rtl/ct_regfile.sv
// Register file: decodes single-cycle writes into the timer control,
// compare, offset and hypervisor control registers.
// Assumes one write per cycle; status bits are not writable.
module ct_regfile
    import ct_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int HCTL_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    output logic [NUM_TMR-1:0]            tmr_en,
    output logic [NUM_TMR-1:0]            tmr_mask,
    output logic [NUM_TMR-1:0][CNT_W-1:0] tmr_cmp,
    output logic [CNT_W-1:0]              virt_off,
    output logic [HCTL_W-1:0]             hyp_ctl
);
    localparam logic [HCTL_W-1:0] HCTL_RST = HCTL_W'(HYP_RESET);

    // Per-timer control and compare registers, repeated for each timer.
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam logic [ADDR_W-1:0] A_CTL = (t == TMR_PHYS) ? A_PHYS_CTL : A_VIRT_CTL;
        localparam logic [ADDR_W-1:0] A_CMP = (t == TMR_PHYS) ? A_PHYS_CMP : A_VIRT_CMP;

        // Capture enable/mask and compare value on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmr_en[t]   <= 1'b0;
                tmr_mask[t] <= 1'b0;
                tmr_cmp[t]  <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_CTL) begin
                    tmr_en[t]   <= wr_data[CTL_EN_BIT];
                    tmr_mask[t] <= wr_data[CTL_MASK_BIT];
                end
                if (wr_addr == A_CMP) begin
                    tmr_cmp[t] <= wr_data;
                end
            end
        end
    end

    // Capture the virtual offset and hypervisor control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            virt_off <= '0;
            hyp_ctl  <= HCTL_RST;
        end else if (wr_en) begin
            if (wr_addr == A_VIRT_OFF) virt_off <= wr_data;
            if (wr_addr == A_HYP_CTL)  hyp_ctl  <= wr_data[HCTL_W-1:0];
        end
    end
endmodule

// File: rtl/ct_compare.sv
// Compare unit for one timer: flags when (count - offset) >= compare,
// using modulo-2^CNT_W subtraction. Gives both the next flag value
// (for the interrupt gate) and the registered flag.
module ct_compare #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] offset,
    input  logic [CNT_W-1:0] cmp,
    input  logic             enable,
    output logic             flag_d,
    output logic             flag_q
);
    logic [CNT_W-1:0] rel_count;

    // Offset-adjusted count and unsigned comparison, gated by enable.
    always_comb begin
        rel_count = count - offset;
        flag_d    = enable && (rel_count >= cmp);
    end

    // Register the status flag.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/ct_irq_gate.sv
// Interrupt gate: combines each timer's next status flag with its own
// mask and the security-qualified hypervisor override, then registers
// the result. Every cycle re-evaluates all inputs.
module ct_irq_gate
    import ct_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sec,
    input  logic [NUM_TMR-1:0] flag_d,
    input  logic [NUM_TMR-1:0] own_mask,
    input  logic [NUM_TMR-1:0] hyp_mask,
    output logic [NUM_TMR-1:0] irq_q
);
    logic              ovr_on;
    logic [NUM_TMR-1:0] irq_d;

    // Decide whether overrides apply and form each timer's next interrupt.
    always_comb begin
        ovr_on = override_active(sec);
        for (int t = 0; t < NUM_TMR; t++) begin
            irq_d[t] = flag_d[t] && !own_mask[t] && !(ovr_on && hyp_mask[t]);
        end
    end

    // Register the interrupt lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/cmp_timer_pair.sv
// Top: physical and virtual compare timers sharing an external count,
// with a hypervisor override mask qualified by security state.
// Assumes sys_count is synchronous to clk.
module cmp_timer_pair
    import ct_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int HCTL_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic [1:0]        sec_state,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              irq_phys,
    output logic              irq_virt,
    output logic              stat_phys,
    output logic              stat_virt
);
    logic [NUM_TMR-1:0]            tmr_en;
    logic [NUM_TMR-1:0]            tmr_mask;
    logic [NUM_TMR-1:0][CNT_W-1:0] tmr_cmp;
    logic [CNT_W-1:0]              virt_off;
    logic [HCTL_W-1:0]             hyp_ctl;
    logic [NUM_TMR-1:0]            flag_d;
    logic [NUM_TMR-1:0]            flag_q;
    logic [NUM_TMR-1:0]            hyp_mask;
    logic [NUM_TMR-1:0]            irq_q;

    ct_regfile #(.CNT_W(CNT_W), .HCTL_W(HCTL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tmr_en   (tmr_en),
        .tmr_mask (tmr_mask),
        .tmr_cmp  (tmr_cmp),
        .virt_off (virt_off),
        .hyp_ctl  (hyp_ctl)
    );

    // One compare unit per timer; only the virtual one sees the offset.
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_cmp
        logic [CNT_W-1:0] off_sel;
        assign off_sel = (t == TMR_VIRT) ? virt_off : '0;

        ct_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .count  (sys_count),
            .offset (off_sel),
            .cmp    (tmr_cmp[t]),
            .enable (tmr_en[t]),
            .flag_d (flag_d[t]),
            .flag_q (flag_q[t])
        );
    end

    // Route the hypervisor override bits to their timers.
    always_comb begin
        hyp_mask[TMR_PHYS] = hyp_ctl[HYP_PMASK_BIT];
        hyp_mask[TMR_VIRT] = hyp_ctl[HYP_VMASK_BIT];
    end

    ct_irq_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec      (sec_state),
        .flag_d   (flag_d),
        .own_mask (tmr_mask),
        .hyp_mask (hyp_mask),
        .irq_q    (irq_q)
    );

    assign irq_phys  = irq_q[TMR_PHYS];
    assign irq_virt  = irq_q[TMR_VIRT];
    assign stat_phys = flag_q[TMR_PHYS];
    assign stat_virt = flag_q[TMR_VIRT];
endmodule

// File: rtl/ct_checker.sv
// Checker: temporal properties of the dual compare timer, bound to the top.
module ct_checker
    import ct_pkg::*;
#(
    parameter int HCTL_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sec_state,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq_phys,
    input logic              irq_virt,
    input logic              stat_phys,
    input logic              stat_virt,
    input logic [1:0]        phys_ctl,
    input logic [1:0]        virt_ctl,
    input logic [HCTL_W-1:0] hctl
);
    // R5: interrupt or status needs the timer enabled in the prior cycle
    a_r5_phys_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_phys |-> $past(phys_ctl[CTL_EN_BIT]));
    a_r5_virt_stat_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        stat_virt |-> $past(virt_ctl[CTL_EN_BIT]));
    // R6: own mask keeps the interrupt low
    a_r6_phys_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_phys |-> !$past(phys_ctl[CTL_MASK_BIT]));
    a_r6_virt_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_virt |-> !$past(virt_ctl[CTL_MASK_BIT]));
    // R7: override in Root/Realm forces the interrupt low
    a_r7_phys_override: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sec_state[1] && hctl[HYP_PMASK_BIT]) |-> !irq_phys);
    a_r7_virt_override: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sec_state[1] && hctl[HYP_VMASK_BIT]) |-> !irq_virt);
    // R2: hypervisor control changes only through a write to its address
    a_r2_hctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(wr_en) && ($past(wr_addr) == ADDR_W'(A_HYP_CTL))) |-> $stable(hctl));
endmodule

bind cmp_timer_pair ct_checker #(.HCTL_W(HCTL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_state (sec_state),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq_phys  (irq_phys),
    .irq_virt  (irq_virt),
    .stat_phys (stat_phys),
    .stat_virt (stat_virt),
    .phys_ctl  ({tmr_mask[0], tmr_en[0]}),
    .virt_ctl  ({tmr_mask[1], tmr_en[1]}),
    .hctl      (hyp_ctl)
);

// File: tb/tb_cmp_timer_pair.sv
`timescale 1ns/1ps
module tb_cmp_timer_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = '0;
    logic [1:0]  sec_state = 2'd1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        irq_phys, irq_virt, stat_phys, stat_virt;
    int          n_chk = 0;
    int          n_bad = 0;

    localparam logic [63:0] HM_V = 64'd1 << 18;
    localparam logic [63:0] HM_P = 64'd1 << 19;

    always #2 clk = ~clk;

    cmp_timer_pair dut (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .sec_state(sec_state),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_phys(irq_phys), .irq_virt(irq_virt),
        .stat_phys(stat_phys), .stat_virt(stat_virt)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Write one register; returns at the negedge after the write edge.
    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Let a write reach the outputs (one more edge).
    task automatic settle;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(irq_phys, 1'b0, "R1", "irq_phys after reset");
        chk(irq_virt, 1'b0, "R1", "irq_virt after reset");
        chk(stat_phys, 1'b0, "R1", "stat_phys after reset");
        chk(stat_virt, 1'b0, "R1", "stat_virt after reset");
        // Enabling with cmp 0 in Root shows bits 18/19 reset clear
        sec_state = 2'd2;
        wr(3'd0, 64'd1); wr(3'd2, 64'd1); settle();
        chk(irq_phys, 1'b1, "R1", "phys fires in Root, reset bit19 clear");
        chk(irq_virt, 1'b1, "R1", "virt fires in Root, reset bit18 clear");
        sec_state = 2'd1;
        wr(3'd0, 64'd0); wr(3'd2, 64'd0); settle();
    endtask

    task automatic t_phys_compare;
        sys_count = 64'd100;
        wr(3'd1, 64'd100); wr(3'd0, 64'd1); settle();
        chk(stat_phys, 1'b1, "R3", "count equals compare");
        chk(irq_phys, 1'b1, "R6", "unmasked irq");
        wr(3'd1, 64'd101); settle();
        chk(stat_phys, 1'b0, "R3", "count one below compare");
        sys_count = '1;
        wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFE); settle();
        chk(stat_phys, 1'b1, "R3", "unsigned top of range");
        sys_count = 64'd1;
        wr(3'd1, '1); settle();
        chk(stat_phys, 1'b0, "R3", "compare at max, count small");
    endtask

    task automatic t_mask_disable;
        sys_count = 64'd500;
        wr(3'd1, 64'd10); wr(3'd0, 64'd3); settle();
        chk(stat_phys, 1'b1, "R6", "masked timer still flags");
        chk(irq_phys, 1'b0, "R6", "own mask holds irq low");
        wr(3'd0, 64'd0); settle();
        chk(stat_phys, 1'b0, "R5", "disabled status");
        chk(irq_phys, 1'b0, "R5", "disabled irq");
    endtask

    task automatic t_virt_offset;
        wr(3'd2, 64'd1);
        sys_count = 64'd50;
        wr(3'd3, 64'd1000); wr(3'd4, 64'd60); settle();
        chk(stat_virt, 1'b1, "R4", "count below offset wraps high");
        wr(3'd4, 64'd0); settle();
        chk(stat_virt, 1'b0, "R4", "no offset, below compare");
        sys_count = 64'd1010;
        wr(3'd4, 64'd10); settle();
        chk(stat_virt, 1'b1, "R4", "offset count equals compare");
        chk(irq_virt, 1'b1, "R6", "virt irq unmasked");
        wr(3'd3, 64'd1001); settle();
        chk(stat_virt, 1'b0, "R4", "offset count one below compare");
        wr(3'd2, 64'd0); settle();
        chk(irq_virt, 1'b0, "R5", "virt disabled");
    endtask

    task automatic t_override;
        sys_count = 64'd5;
        wr(3'd1, 64'd0); wr(3'd3, 64'd0); wr(3'd4, 64'd0);
        wr(3'd0, 64'd1); wr(3'd2, 64'd1);
        sec_state = 2'd0;
        wr(3'd5, 64'd3 | HM_V | HM_P); settle();
        chk(irq_phys, 1'b1, "R8", "Secure ignores bit19");
        chk(irq_virt, 1'b1, "R8", "Secure ignores bit18");
        @(negedge clk); sec_state = 2'd1; @(negedge clk);
        chk(irq_phys, 1'b1, "R8", "Non-secure ignores bit19");
        chk(irq_virt, 1'b1, "R8", "Non-secure ignores bit18");
        sec_state = 2'd3; @(negedge clk);
        chk(irq_phys, 1'b0, "R9", "Realm entry drops phys same edge");
        chk(irq_virt, 1'b0, "R9", "Realm entry drops virt same edge");
        sec_state = 2'd2; @(negedge clk);
        chk(irq_phys, 1'b0, "R7", "Root bit19");
        wr(3'd5, 64'd3 | HM_V); settle();
        chk(irq_virt, 1'b0, "R7", "bit18 masks virt only");
        chk(irq_phys, 1'b1, "R7", "bit18 leaves phys");
        wr(3'd5, 64'd3 | HM_P); settle();
        chk(irq_phys, 1'b0, "R10", "swap both bits: phys low");
        chk(irq_virt, 1'b1, "R10", "swap both bits: virt high");
        sec_state = 2'd1; @(negedge clk);
        chk(irq_phys, 1'b1, "R9", "leave Root restores phys");
    endtask

    task automatic t_same_edge;
        sec_state = 2'd0;
        wr(3'd5, 64'd3 | HM_V | HM_P); settle();
        @(negedge clk);
        sec_state = 2'd2; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 64'd3;
        @(negedge clk);
        wr_en = 1'b0;
        chk(irq_phys, 1'b0, "R11", "same edge: old bit19 with Root");
        chk(irq_virt, 1'b0, "R11", "same edge: old bit18 with Root");
        @(negedge clk);
        chk(irq_phys, 1'b1, "R10", "both bits cleared: phys");
        chk(irq_virt, 1'b1, "R10", "both bits cleared: virt");
    endtask

    task automatic t_latency;
        sec_state = 2'd1;
        sys_count = 64'd100;
        wr(3'd1, 64'd200); settle();
        chk(stat_phys, 1'b0, "R11", "setup below compare");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 64'd100;
        @(negedge clk);
        wr_en = 1'b0;
        chk(stat_phys, 1'b0, "R11", "write not yet visible");
        @(negedge clk);
        chk(stat_phys, 1'b1, "R11", "write visible one edge later");
        sys_count = 64'd50;
        @(negedge clk);
        chk(stat_phys, 1'b0, "R11", "count change after one edge");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phys_compare();
        t_mask_disable();
        t_virt_offset();
        t_override();
        t_same_edge();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule